// File: doc/BRIEF.md
# Holdover-Capable Synthesized Bus Clock Generator

This block makes a telecom bus clock, nominally 8 MHz, from a stable oscillator whose own frequency is fixed. A phase accumulator adds a tuning word on every oscillator cycle. Its most significant bit is the output clock, so the output frequency is `F_OSC * word / 2^ACC_W`. The oscillator has to run at two times the output frequency or more, and the default ratio is eight. The accumulator width is a parameter, with a default of 48 bits.

While a qualified reference is present, a frequency loop steers the tuning word. The loop counts oscillator cycles between reference rising edges and compares the count with the expected period. It then applies a proportional-plus-integral correction, scaled by shifts. If the reference goes missing or is flagged invalid, the block enters holdover: the word freezes at its last tracked value and the output keeps running at that frequency. Tracking comes back only after a programmable run of well-spaced edges. It then restarts from the held word, not from the nominal one. A direct load port can force the word at any time.

Top module: `dds_holdover_clkgen`

## Requirements
- R1: `clk_out` is the top bit of an accumulator that starts at 0 and adds `tw_out` on every clock. With the default word (64 MHz oscillator, 8 MHz output), `clk_out` has a period of 8 clocks with 4 high and 4 low, and it first reads 1 after the 4th clock edge following reset release.
- R2: During reset, `tw_out` equals floor(F_OUT_HZ * 2^ACC_W / F_OSC_HZ), `holdover` is 1 and `clk_out` is 0.
- R3: A reference edge is a cycle in which `ref_in` is 1 and was 0 on the previous clock. The measured period is the number of clocks from one edge to the next.
- R4: Each edge outside holdover updates the word as follows. err = cfg_exp_period - period, and s = err * 2^ERR_SHL. The integrator becomes I + (s >>> KI_SHIFT), and `tw_out` becomes the new I + (s >>> KP_SHIFT). Both use arithmetic shifts and wrap modulo 2^ACC_W. The new word is visible one clock after the edge.
- R5: In holdover, reference edges never change `tw_out`. Only a load can change it.
- R6: Outside holdover, if `ref_ok` is 0, or if the count since the last edge reaches `cfg_timeout` with no edge in that cycle, then `holdover` reads 1 in that same cycle. An edge in that cycle makes no update.
- R7: Entering holdover sets the integrator to the held word. The first update after recovery is therefore applied on top of the held word, not on top of the nominal word.
- R8: Holdover clears one clock after the `cfg_qual`-th consecutive edge that has `ref_ok`=1 and a period inside [cfg_exp_period - cfg_window, cfg_exp_period + cfg_window], bounds included. Any edge outside that window, or any edge with `ref_ok`=0, restarts the count.
- R9: `tw_load`=1 sets both `tw_out` and the integrator to `tw_load_val` one clock later, in either state, and it takes priority over an edge update.
- R10: After a load, the output frequency follows the new word. A word of 2^(ACC_W-2) gives exactly 8 rising edges of `clk_out` in 32 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Stable oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Reference input, synchronous to clk_osc |
| ref_ok | input | 1 | External reference-valid qualifier |
| cfg_exp_period | input | PER_W | Expected reference period in oscillator cycles |
| cfg_window | input | PER_W | Allowed period deviation for requalification |
| cfg_timeout | input | PER_W | Cycles without an edge that declare loss |
| cfg_qual | input | QUAL_W | Consecutive good edges needed to resume tracking |
| tw_load | input | 1 | Direct tuning-word load strobe |
| tw_load_val | input | ACC_W | Word applied by tw_load |
| clk_out | output | 1 | Synthesized clock |
| holdover | output | 1 | 1 while the word is frozen |
| tw_out | output | ACC_W | Current tuning word |

## Verification
Two events can fall in the same cycle: a reference edge that would update the loop, and a loss declaration. The bench provokes the collision by lowering `ref_okay`-style qualifier `ref_ok` in exactly the cycle a well-spaced edge arrives. It then samples `holdover` in that cycle before the clock edge and expects 1. After the edge it expects `tw_out` to be unchanged, and the scoreboard also sees no change. A second coincidence is the requalifying edge, which ends holdover but must not update the word itself. The scoreboard would flag any change of the word at that point as unexpected.

// File: rtl/dds_hold_pkg.sv
package dds_hold_pkg;

  typedef logic signed [63:0] wide_s_t;

  // Nominal word: floor(fout * 2^accw / fosc), computed wide to avoid overflow.
  function automatic logic [127:0] nominal_word(input longint unsigned fosc,
                                                input longint unsigned fout,
                                                input int unsigned     accw);
    logic [127:0] num;
    num = 128'(fout) << accw;
    return num / 128'(fosc);
  endfunction

  // Period error in cycles scaled up into tuning-word units.
  function automatic wide_s_t scale_err(input wide_s_t err, input int unsigned up);
    return err <<< up;
  endfunction

  // Arithmetic right shift used for both loop gains.
  function automatic wide_s_t gain_shr(input wide_s_t v, input int unsigned dn);
    return v >>> dn;
  endfunction

  // Inclusive acceptance window around the expected period.
  function automatic logic in_window(input logic [31:0] period,
                                     input logic [31:0] expv,
                                     input logic [31:0] win);
    logic [32:0] lo;
    logic [32:0] hi;
    lo = (expv > win) ? {1'b0, expv - win} : 33'd0;
    hi = {1'b0, expv} + {1'b0, win};
    return ({1'b0, period} >= lo) && ({1'b0, period} <= hi);
  endfunction

endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int ACC_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] tw,
  output logic             msb_o
);
  logic [ACC_W-1:0] acc;

  always_ff @(posedge clk) begin
    if (!rst_n) acc <= '0;
    else        acc <= acc + tw;
  end

  assign msb_o = acc[ACC_W-1];

endmodule

// File: rtl/ref_monitor.sv
module ref_monitor
  import dds_hold_pkg::*;
#(
  parameter int PER_W  = 16,
  parameter int QUAL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_in,
  input  logic              ref_ok,
  input  logic [PER_W-1:0]  cfg_exp_period,
  input  logic [PER_W-1:0]  cfg_window,
  input  logic [PER_W-1:0]  cfg_timeout,
  input  logic [QUAL_W-1:0] cfg_qual,
  output logic              hold_o,
  output logic              upd_o,
  output logic [PER_W-1:0]  period_o
);
  localparam logic [PER_W-1:0] GAP_MAX = '1;

  logic              ref_d;
  logic              edge_w;
  logic [PER_W-1:0]  gap;
  logic              hold_q;
  logic [QUAL_W-1:0] qual_cnt;
  logic              timeout_hit;
  logic              lose_now;
  logic              qual_ok;
  logic              qual_done;
  logic [QUAL_W:0]   qual_next;

  assign edge_w      = ref_in & ~ref_d;
  assign timeout_hit = (gap >= cfg_timeout) & ~edge_w;
  assign lose_now    = ~hold_q & (~ref_ok | timeout_hit);
  assign qual_ok     = edge_w & ref_ok &
                       in_window(32'(gap), 32'(cfg_exp_period), 32'(cfg_window));
  assign qual_next   = {1'b0, qual_cnt} + 1'b1;
  assign qual_done   = hold_q & qual_ok & (qual_next >= {1'b0, cfg_qual});

  assign hold_o   = hold_q | lose_now;
  assign upd_o    = edge_w & ~hold_o;
  assign period_o = gap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_d <= 1'b0;
      gap   <= '0;
    end else begin
      ref_d <= ref_in;
      if (edge_w)              gap <= {{(PER_W-1){1'b0}}, 1'b1};
      else if (gap != GAP_MAX) gap <= gap + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q   <= 1'b1;
      qual_cnt <= '0;
    end else begin
      if (lose_now)       hold_q <= 1'b1;
      else if (qual_done) hold_q <= 1'b0;

      if (!hold_q)     qual_cnt <= '0;
      else if (edge_w) qual_cnt <= (qual_ok && !qual_done) ? qual_next[QUAL_W-1:0] : '0;
    end
  end

  AST_EXIT_NEEDS_GOOD_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_q) |-> $past(edge_w && ref_ok)); // R8
  AST_INVALID_ENTERS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_q && !ref_ok) |=> hold_q); // R6
  AST_GAP_BOUNDED_TRACKING: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_q |-> (gap <= cfg_timeout)); // R6

endmodule

// File: rtl/tune_loop.sv
module tune_loop
  import dds_hold_pkg::*;
#(
  parameter int                 ACC_W    = 48,
  parameter int                 PER_W    = 16,
  parameter int                 ERR_SHL  = 30,
  parameter int                 KP_SHIFT = 1,
  parameter int                 KI_SHIFT = 3,
  parameter logic [ACC_W-1:0]   RESET_TW = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic             hold,
  input  logic [PER_W-1:0] period,
  input  logic [PER_W-1:0] cfg_exp_period,
  input  logic             load,
  input  logic [ACC_W-1:0] load_val,
  output logic [ACC_W-1:0] tw
);
  logic [ACC_W-1:0] integ;
  logic [ACC_W-1:0] integ_next;
  logic [ACC_W-1:0] tw_next;
  wide_s_t          err_w;
  wide_s_t          scaled_w;

  assign err_w      = wide_s_t'(64'(cfg_exp_period)) - wide_s_t'(64'(period));
  assign scaled_w   = scale_err(err_w, ERR_SHL);
  assign integ_next = integ + ACC_W'(gain_shr(scaled_w, KI_SHIFT));
  assign tw_next    = integ_next + ACC_W'(gain_shr(scaled_w, KP_SHIFT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      integ <= RESET_TW;
      tw    <= RESET_TW;
    end else if (load) begin
      integ <= load_val;
      tw    <= load_val;
    end else if (upd) begin
      integ <= integ_next;
      tw    <= tw_next;
    end else if (hold) begin
      integ <= tw;
    end
  end

  AST_FROZEN_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !load) |=> $stable(tw)); // R5
  AST_RESUME_FROM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !load) |=> (integ == tw)); // R7
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (tw == $past(load_val))); // R9
  AST_NO_UPDATE_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    upd |-> !hold); // R6

endmodule

// File: rtl/dds_holdover_clkgen.sv
module dds_holdover_clkgen
  import dds_hold_pkg::*;
#(
  parameter int              ACC_W    = 48,
  parameter int              PER_W    = 16,
  parameter int              QUAL_W   = 4,
  parameter int              ERR_SHL  = 30,
  parameter int              KP_SHIFT = 1,
  parameter int              KI_SHIFT = 3,
  parameter longint unsigned F_OSC_HZ = 64_000_000,
  parameter longint unsigned F_OUT_HZ = 8_000_000
) (
  input  logic              clk_osc,
  input  logic              rst_n,
  input  logic              ref_in,
  input  logic              ref_ok,
  input  logic [PER_W-1:0]  cfg_exp_period,
  input  logic [PER_W-1:0]  cfg_window,
  input  logic [PER_W-1:0]  cfg_timeout,
  input  logic [QUAL_W-1:0] cfg_qual,
  input  logic              tw_load,
  input  logic [ACC_W-1:0]  tw_load_val,
  output logic              clk_out,
  output logic              holdover,
  output logic [ACC_W-1:0]  tw_out
);
  localparam logic [ACC_W-1:0] NOM_TW = ACC_W'(nominal_word(F_OSC_HZ, F_OUT_HZ, ACC_W));

  logic             hold_w;
  logic             upd_w;
  logic [PER_W-1:0] period_w;
  logic [ACC_W-1:0] tw_w;

  ref_monitor #(.PER_W(PER_W), .QUAL_W(QUAL_W)) u_mon (
    .clk            (clk_osc),
    .rst_n          (rst_n),
    .ref_in         (ref_in),
    .ref_ok         (ref_ok),
    .cfg_exp_period (cfg_exp_period),
    .cfg_window     (cfg_window),
    .cfg_timeout    (cfg_timeout),
    .cfg_qual       (cfg_qual),
    .hold_o         (hold_w),
    .upd_o          (upd_w),
    .period_o       (period_w)
  );

  tune_loop #(
    .ACC_W(ACC_W), .PER_W(PER_W), .ERR_SHL(ERR_SHL),
    .KP_SHIFT(KP_SHIFT), .KI_SHIFT(KI_SHIFT), .RESET_TW(NOM_TW)
  ) u_loop (
    .clk            (clk_osc),
    .rst_n          (rst_n),
    .upd            (upd_w),
    .hold           (hold_w),
    .period         (period_w),
    .cfg_exp_period (cfg_exp_period),
    .load           (tw_load),
    .load_val       (tw_load_val),
    .tw             (tw_w)
  );

  dds_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk   (clk_osc),
    .rst_n (rst_n),
    .tw    (tw_w),
    .msb_o (clk_out)
  );

  assign holdover = hold_w;
  assign tw_out   = tw_w;

  AST_RESET_STATE: assert property (@(posedge clk_osc)
    !rst_n |=> (holdover && (tw_out == NOM_TW) && !clk_out)); // R2

endmodule

// File: tb/dds_holdover_clkgen_bench.sv
`timescale 1ns/1ps
module dds_holdover_clkgen_bench;
  localparam int ACC_W  = 48;
  localparam int PER_W  = 16;
  localparam int QUAL_W = 4;
  localparam int EXP_P  = 40;
  localparam logic [ACC_W-1:0] NOM = 48'h1 << 45; // 2^48 * 8 / 64

  logic              clk = 1'b0;
  logic              rst_n, ref_in, ref_ok, tw_load;
  logic [PER_W-1:0]  cfg_exp_period, cfg_window, cfg_timeout;
  logic [QUAL_W-1:0] cfg_qual;
  logic [ACC_W-1:0]  tw_load_val;
  logic              clk_out, holdover;
  logic [ACC_W-1:0]  tw_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  bit mon_en  = 0;
  logic [ACC_W-1:0] exp_q[$];
  logic [ACC_W-1:0] last_tw;
  logic [ACC_W-1:0] m_integ, m_tw;

  always #5 clk = ~clk;

  dds_holdover_clkgen u_dds_holdover_clkgen (
    .clk_osc(clk), .rst_n(rst_n), .ref_in(ref_in), .ref_ok(ref_ok),
    .cfg_exp_period(cfg_exp_period), .cfg_window(cfg_window),
    .cfg_timeout(cfg_timeout), .cfg_qual(cfg_qual),
    .tw_load(tw_load), .tw_load_val(tw_load_val),
    .clk_out(clk_out), .holdover(holdover), .tw_out(tw_out)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Driver side of the scoreboard: model of the frequency loop.
  task automatic model_edge(input int period);
    logic signed [63:0] s;
    logic [ACC_W-1:0]   nt;
    s       = longint'(EXP_P - period) * 64'sd1073741824;
    m_integ = m_integ + ACC_W'(s / 8);
    nt      = m_integ + ACC_W'(s / 2);
    if (nt != m_tw) exp_q.push_back(nt);
    m_tw = nt;
  endtask

  task automatic send_ref(input int p);
    repeat (p - 1) @(negedge clk);
    ref_in = 1'b1;
    @(negedge clk);
    ref_in = 1'b0;
  endtask

  task automatic do_load(input logic [ACC_W-1:0] v);
    tw_load = 1'b1; tw_load_val = v;
    if (v != m_tw) exp_q.push_back(v);
    m_tw = v; m_integ = v;
    @(negedge clk);
    tw_load = 1'b0;
  endtask

  // Monitor side: every observed change of the word must match the next expected one.
  always @(negedge clk) begin
    if (mon_en && (tw_out !== last_tw)) begin
      if (exp_q.size() == 0) chk(1'b0, "R5 unexpected word change", tw_out, last_tw);
      else begin
        logic [ACC_W-1:0] e;
        e = exp_q.pop_front();
        chk(tw_out == e, "R4/R9 word update", tw_out, e);
      end
    end
    last_tw = tw_out;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int highs, rises, first;
    logic prev;
    rst_n = 0; ref_in = 0; ref_ok = 1; tw_load = 0; tw_load_val = '0;
    cfg_exp_period = 16'(EXP_P); cfg_window = 16'd2; cfg_timeout = 16'd60; cfg_qual = 4'd3;
    m_tw = NOM; m_integ = NOM;
    repeat (3) @(negedge clk);
    chk(holdover == 1'b1, "R2 holdover in reset", 64'(holdover), 1);
    chk(tw_out == NOM, "R2 nominal word", 64'(tw_out), 64'(NOM));
    chk(clk_out == 1'b0, "R2 clk_out in reset", 64'(clk_out), 0);
    last_tw = tw_out; mon_en = 1;
    rst_n = 1;

    // R1: free run on the nominal word
    highs = 0; rises = 0; first = -1; prev = 1'b0;
    for (int k = 1; k <= 64; k++) begin
      @(negedge clk);
      if (clk_out) highs++;
      if (clk_out && !prev) begin rises++; if (first < 0) first = k; end
      prev = clk_out;
    end
    chk(first == 4, "R1 first high after 4th edge", 64'(first), 4);
    chk(highs == 32, "R1 duty", 64'(highs), 32);
    chk(rises == 8, "R1 period 8", 64'(rises), 8);

    // R8 / R3: qualification with window boundaries
    send_ref(40); send_ref(40); send_ref(40); send_ref(43);
    chk(holdover == 1'b1, "R8 period exp+win+1 resets count", 64'(holdover), 1);
    send_ref(40); send_ref(40);
    chk(holdover == 1'b1, "R8 two good edges not enough", 64'(holdover), 1);
    send_ref(42);
    chk(holdover == 1'b0, "R8 exp+win qualifies", 64'(holdover), 0);
    chk(tw_out == NOM, "R8 qualifying edge makes no update", 64'(tw_out), 64'(NOM));

    // R4: tracking under several periods
    model_edge(40); send_ref(40);
    model_edge(38); send_ref(38);
    model_edge(42); send_ref(42);
    model_edge(37); send_ref(37);
    model_edge(44); send_ref(44);
    chk(tw_out == m_tw, "R4 tracked word", 64'(tw_out), 64'(m_tw));

    // R6: timeout
    repeat (58) @(negedge clk);
    chk(holdover == 1'b0, "R6 one cycle before timeout", 64'(holdover), 0);
    @(negedge clk);
    chk(holdover == 1'b1, "R6 flag at timeout", 64'(holdover), 1);
    m_integ = m_tw;

    // R5: edges in holdover do nothing
    send_ref(30); send_ref(30); send_ref(30);
    chk(tw_out == m_tw, "R5 word frozen", 64'(tw_out), 64'(m_tw));
    chk(holdover == 1'b1, "R5 still holding", 64'(holdover), 1);

    // R7: resume from held word
    send_ref(40); send_ref(40); send_ref(40);
    chk(holdover == 1'b0, "R8 requalified", 64'(holdover), 0);
    model_edge(38); send_ref(38);
    chk(tw_out == m_tw, "R7 update relative to held word", 64'(tw_out), 64'(m_tw));

    // R6 collision: loss in the same cycle as a good edge
    repeat (39) @(negedge clk);
    ref_in = 1'b1; ref_ok = 1'b0;
    #1;
    chk(holdover == 1'b1, "R6 flag same cycle as edge", 64'(holdover), 1);
    @(negedge clk);
    ref_in = 1'b0;
    chk(tw_out == m_tw, "R6 no update on loss edge", 64'(tw_out), 64'(m_tw));
    m_integ = m_tw;
    send_ref(40); send_ref(40); send_ref(40);
    chk(holdover == 1'b1, "R8 ref_ok low blocks recovery", 64'(holdover), 1);
    ref_ok = 1'b1;
    send_ref(40); send_ref(40); send_ref(40);
    chk(holdover == 1'b0, "R8 recovery after ref_ok", 64'(holdover), 0);

    // R9 / R10: direct load
    do_load(48'h1 << 46);
    chk(tw_out == (48'h1 << 46), "R9 load while tracking", 64'(tw_out), 64'(48'h1 << 46));
    rises = 0; prev = clk_out;
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      if (clk_out && !prev) rises++;
      prev = clk_out;
    end
    chk(rises == 8, "R10 loaded word sets frequency", 64'(rises), 8);
    repeat (40) @(negedge clk);
    chk(holdover == 1'b1, "R6 timeout after load", 64'(holdover), 1);
    do_load(NOM);
    chk(tw_out == NOM, "R9 load in holdover", 64'(tw_out), 64'(NOM));

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all expected updates seen", 64'(exp_q.size()), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule